// File: doc/BRIEF.md
# Slave-Ready Handshake Sequencer for a Five-Wire SPI Master

This block wraps each word an SPI master sends, when the slave drives an extra ready line (here called `slave_en`, active high) back to the master. It lowers chip select, waits a programmed setup time, and then either starts the shift engine or waits for the slave. After the engine reports completion, it holds chip select for a programmed hold time. It can then watch for the slave to release its ready line, and it runs a programmed gap before the next word.

The ready line can end either optional wait window early. It also decides the outcome of each word. If the slave never answers before the first transfer, a timeout is raised. If the slave does not release the line after the transfer, a desync error is raised. If the slave released the line, the next word waits for it. If the slave kept the line high through every post-transfer phase, the next word starts immediately and ignores the line.

An external shift engine receives a one-cycle start pulse and returns a one-cycle done pulse. Five 8-bit delay values are given in module clock cycles. Two sticky error flags each have a one-cycle event pulse and share one clear input.

Top module: `hs_handshake_seq`

## Requirements
- R1: After reset `cs_n` is 1, `eng_start` is 0, and both error flags and both event pulses are 0.
- R2: `eng_start` rises exactly L cycles after `cs_n` falls when the synchronised ready line is high at the end of the setup phase, where L is the setup value, or 1 when the value is 0. The pre-transfer window is skipped in that case.
- R3: When the ready line rises during the pre-transfer window, that window ends and `eng_start` rises 3 cycles after the input changes: 2 cycles for synchronisation and 1 registered cycle.
- R4: When the ready line is still low as a non-zero pre-transfer window of W cycles expires, `timeout_evt` pulses L+W cycles after `cs_n` falls. `cs_n` returns to 1 in that same cycle, and the pending word is discarded without any `eng_start`.
- R5: A pre-transfer window value of 0 means the sequencer waits for the ready line with no limit and never raises a timeout.
- R6: When the ready line drops during the hold phase, the hold phase still runs in full, the post-transfer window is skipped, and no desync is raised.
- R7: When the ready line drops inside the post-transfer window, the window ends at once and no desync is raised.
- R8: When the ready line is still high as a non-zero post-transfer window of T cycles expires, `desync_evt` pulses M+T cycles after the done pulse is sampled, where M is the hold value, or 1 when the value is 0. A window value of 0 never raises desync.
- R9: If the ready line was low at any point in the post-transfer phases, the next word does not lower `cs_n` until the ready line is high again. `cs_n` then falls 3 cycles after the input rises.
- R10: If the ready line stayed high through every post-transfer phase, the next word starts L cycles after `cs_n` falls, even when the ready line is low.
- R11: Both error flags stay set until `err_clr`. When a clear and a new error fall in the same cycle, the error wins. Each event pulse lasts one cycle.
- R12: `eng_start` lasts one cycle while `cs_n` is 0. `cs_n` returns to 1 exactly M cycles after the done pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_req | input | 1 | One-cycle request to send a word |
| eng_start | output | 1 | One-cycle start pulse to the shift engine |
| eng_done | input | 1 | One-cycle completion pulse from the shift engine |
| cs_n | output | 1 | Chip select, active low |
| slave_en | input | 1 | Asynchronous ready line from the slave, active high |
| cfg_c2t | input | 8 | Setup cycles from chip select to transfer |
| cfg_c2e | input | 8 | Pre-transfer ready window, 0 = unlimited |
| cfg_t2c | input | 8 | Hold cycles from transfer end to chip select release |
| cfg_t2e | input | 8 | Post-transfer release window, 0 = disabled |
| cfg_wait | input | 8 | Gap cycles between words |
| err_clr | input | 1 | Clears both sticky error flags |
| timeout_flag | output | 1 | Sticky timeout error |
| timeout_evt | output | 1 | One-cycle timeout event |
| desync_flag | output | 1 | Sticky desync error |
| desync_evt | output | 1 | One-cycle desync event |

## Verification
A timeout that raises its sticky flag can land in the same clock edge as a software clear. A desync event can meet a clear in the same way. The bench counts cycles from the fall of chip select, which is known to be L+W, and drives `err_clr` so that it is sampled on exactly the edge where the timeout fires. It then judges that the flag reads 1 after that edge and 0 only after a later, lone clear. A second overlap comes from the ready line: a drop during the hold phase must win over the post-transfer window that would otherwise follow. The bench checks this by the absence of desync and by the held next word.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PREW  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_HOLD  = 3'd4,
    ST_POSTW = 3'd5,
    ST_GAP   = 3'd6
  } hs_state_t;

  // A programmed count of zero still costs one transition cycle.
  function automatic int phase_len(int n);
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hs_phase_cnt.sv
module hs_phase_cnt
  import hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic          last
);
  localparam int CW = DW + 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= CW'(phase_len(int'(load_val)));
    else if (cnt_q > 1)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/hs_err_flag.sv
module hs_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag,
  output logic evt
);
  logic flag_q, evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q  <= set;
      flag_q <= set | (flag_q & ~clr);
    end
  end

  assign flag = flag_q;
  assign evt  = evt_q;

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  assert_evt_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> flag_q);
  assert_evt_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !set) |=> !evt_q);
endmodule

// File: rtl/hs_handshake_seq.sv
module hs_handshake_seq
  import hs_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_req,
  output logic          eng_start,
  input  logic          eng_done,
  output logic          cs_n,
  input  logic          slave_en,
  input  logic [DW-1:0] cfg_c2t,
  input  logic [DW-1:0] cfg_c2e,
  input  logic [DW-1:0] cfg_t2c,
  input  logic [DW-1:0] cfg_t2e,
  input  logic [DW-1:0] cfg_wait,
  input  logic          err_clr,
  output logic          timeout_flag,
  output logic          timeout_evt,
  output logic          desync_flag,
  output logic          desync_evt
);
  hs_state_t st_q, st_d;
  logic en_s;
  logic ph_last, ld;
  logic [DW-1:0] ld_val;
  logic fire_start, fire_to, fire_ds;
  logic pending_q, hold_q, fast_q, drop_q;
  logic cs_n_q, start_q;
  logic gap_end, gap_dropped;

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(slave_en), .q(en_s));

  hs_phase_cnt #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .last(ph_last));

  always_comb begin
    st_d       = st_q;
    ld         = 1'b0;
    ld_val     = cfg_wait;
    fire_start = 1'b0;
    fire_to    = 1'b0;
    fire_ds    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (pending_q && (!hold_q || en_s)) begin
        st_d = ST_SETUP; ld = 1'b1; ld_val = cfg_c2t;
      end
      ST_SETUP: if (ph_last) begin
        if (fast_q || en_s) begin
          st_d = ST_SHIFT; fire_start = 1'b1;
        end else begin
          st_d = ST_PREW; ld = 1'b1; ld_val = cfg_c2e;
        end
      end
      ST_PREW: begin
        if (en_s) begin
          st_d = ST_SHIFT; fire_start = 1'b1;
        end else if ((cfg_c2e != '0) && ph_last) begin
          st_d = ST_IDLE; fire_to = 1'b1;
        end
      end
      ST_SHIFT: if (eng_done) begin
        st_d = ST_HOLD; ld = 1'b1; ld_val = cfg_t2c;
      end
      ST_HOLD: if (ph_last) begin
        if (!drop_q && en_s && (cfg_t2e != '0)) begin
          st_d = ST_POSTW; ld = 1'b1; ld_val = cfg_t2e;
        end else begin
          st_d = ST_GAP; ld = 1'b1;
        end
      end
      ST_POSTW: begin
        if (!en_s) begin
          st_d = ST_GAP; ld = 1'b1;
        end else if (ph_last) begin
          st_d = ST_GAP; ld = 1'b1; fire_ds = 1'b1;
        end
      end
      ST_GAP: if (ph_last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign gap_end     = (st_q == ST_GAP) && ph_last;
  assign gap_dropped = drop_q || !en_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cs_n_q    <= 1'b1;
      start_q   <= 1'b0;
      pending_q <= 1'b0;
      hold_q    <= 1'b0;
      fast_q    <= 1'b0;
      drop_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      cs_n_q    <= !(st_d inside {ST_SETUP, ST_PREW, ST_SHIFT, ST_HOLD});
      start_q   <= fire_start;
      pending_q <= word_req | (pending_q & ~(fire_start | fire_to));
      if (st_q == ST_SHIFT)
        drop_q <= 1'b0;
      else if ((st_q inside {ST_HOLD, ST_POSTW, ST_GAP}) && !en_s)
        drop_q <= 1'b1;
      if (gap_end) begin
        hold_q <= gap_dropped;
        fast_q <= !gap_dropped;
      end else begin
        if ((st_q == ST_IDLE) && (st_d != ST_IDLE)) hold_q <= 1'b0;
        if (fire_start || fire_to) fast_q <= 1'b0;
      end
    end
  end

  assign eng_start = start_q;
  assign cs_n      = cs_n_q;

  hs_err_flag u_timeout (
    .clk(clk), .rst_n(rst_n), .set(fire_to), .clr(err_clr),
    .flag(timeout_flag), .evt(timeout_evt));

  hs_err_flag u_desync (
    .clk(clk), .rst_n(rst_n), .set(fire_ds), .clr(err_clr),
    .flag(desync_flag), .evt(desync_evt));

  assert_start_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  assert_start_selected_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !cs_n);
  assert_timeout_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> cs_n);
  assert_timeout_needs_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> ($past(cfg_c2e) != '0));
  assert_desync_needs_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desync_evt |-> ($past(cfg_t2e) != '0));
  assert_held_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && hold_q && !en_s) |=> cs_n);
  assert_no_start_after_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_to |=> !eng_start);
endmodule

// File: tb/tb_hs_handshake_seq.sv
module tb_hs_handshake_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_req = 1'b0, eng_done = 1'b0, slave_en = 1'b0, err_clr = 1'b0;
  logic [7:0] cfg_c2t = '0, cfg_c2e = '0, cfg_t2c = '0, cfg_t2e = '0, cfg_wait = '0;
  logic eng_start, cs_n, timeout_flag, timeout_evt, desync_flag, desync_evt;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hs_handshake_seq dut (
    .clk(clk), .rst_n(rst_n), .word_req(word_req), .eng_start(eng_start),
    .eng_done(eng_done), .cs_n(cs_n), .slave_en(slave_en),
    .cfg_c2t(cfg_c2t), .cfg_c2e(cfg_c2e), .cfg_t2c(cfg_t2c), .cfg_t2e(cfg_t2e),
    .cfg_wait(cfg_wait), .err_clr(err_clr), .timeout_flag(timeout_flag),
    .timeout_evt(timeout_evt), .desync_flag(desync_flag), .desync_evt(desync_evt));

  // columns: setup, pre window, hold, post window, gap, ready before, drop at done
  localparam int VEC [6][7] = '{
    '{5, 0, 4, 6, 3, 1, 0},
    '{0, 0, 2, 0, 0, 1, 0},
    '{3, 7, 4, 5, 2, 0, 0},
    '{6, 4, 4, 3, 2, 1, 1},
    '{2, 9, 3, 2, 4, 0, 0},
    '{8, 2, 5, 7, 1, 1, 0}
  };

  function automatic int len_of(int n);
    if (n == 0) return 1;
    return n;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; word_req = 1'b0; eng_done = 1'b0; err_clr = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic set_cfg(input int a, input int b, input int c, input int d, input int e);
    cfg_c2t = 8'(a); cfg_c2e = 8'(b); cfg_t2c = 8'(c); cfg_t2e = 8'(d); cfg_wait = 8'(e);
  endtask

  task automatic req_word();
    word_req = 1'b1; tick(); word_req = 1'b0;
  endtask

  task automatic wait_cs(output int k);
    k = 0;
    while (cs_n !== 1'b0 && k < 60) begin tick(); k++; end
  endtask

  task automatic wait_start_or_to(output int n, output int kind);
    n = 0; kind = 0;
    while (kind == 0 && n < 600) begin
      tick(); n++;
      if (eng_start === 1'b1) kind = 1;
      else if (timeout_evt === 1'b1) kind = 2;
    end
  endtask

  // ends the running word; reports cycles to cs release and to desync (-1 if none)
  task automatic finish_word(input bit drop, output int m_cs, output int m_ds);
    repeat (3) tick();
    if (drop) slave_en = 1'b0;
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    m_cs = -1; m_ds = -1;
    for (int m = 1; m <= 80; m++) begin
      tick();
      if (m_cs < 0 && cs_n === 1'b1) m_cs = m;
      if (m_ds < 0 && desync_evt === 1'b1) m_ds = m;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, kind, k, m_cs, m_ds, starts;

    // R1 reset state
    do_reset();
    check("R1 cs_n", int'(cs_n), 1);
    check("R1 eng_start", int'(eng_start), 0);
    check("R1 flags", int'(timeout_flag) + int'(desync_flag) + int'(timeout_evt) + int'(desync_evt), 0);

    // table walk
    for (int r = 0; r < 6; r++) begin
      do_reset();
      set_cfg(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3], VEC[r][4]);
      slave_en = VEC[r][5] != 0;
      repeat (4) tick();
      req_word();
      wait_cs(k);
      wait_start_or_to(n, kind);
      if (VEC[r][5] != 0) begin
        check("R2 start kind", kind, 1);
        check("R2 start delay", n, len_of(VEC[r][0]));
        finish_word(VEC[r][6] != 0, m_cs, m_ds);
        check("R12 cs release", m_cs, len_of(VEC[r][2]));
        if (VEC[r][6] == 0 && VEC[r][3] != 0) begin
          check("R8 desync delay", m_ds, len_of(VEC[r][2]) + VEC[r][3]);
          check("R8 desync flag", int'(desync_flag), 1);
        end else begin
          check("R6 R8 no desync", m_ds, -1);
          check("R6 R8 desync flag", int'(desync_flag), 0);
        end
      end else begin
        check("R4 timeout kind", kind, 2);
        check("R4 timeout delay", n, len_of(VEC[r][0]) + VEC[r][1]);
        check("R4 cs released", int'(cs_n), 1);
        check("R4 flag", int'(timeout_flag), 1);
        starts = 0;
        for (int i = 0; i < 30; i++) begin
          tick();
          starts += int'(eng_start) + int'(!cs_n);
        end
        check("R4 word discarded", starts, 0);
      end
    end

    // R10 fast path: ready held high through all post phases, then dropped
    do_reset();
    set_cfg(4, 0, 3, 2, 2);
    slave_en = 1'b1; repeat (4) tick();
    req_word(); wait_cs(k); wait_start_or_to(n, kind);
    finish_word(1'b0, m_cs, m_ds);
    slave_en = 1'b0; repeat (4) tick();
    req_word(); wait_cs(k);
    wait_start_or_to(n, kind);
    check("R10 start ignoring ready kind", kind, 1);
    check("R10 start ignoring ready delay", n, 4);
    finish_word(1'b0, m_cs, m_ds);
    check("R6 no desync with ready low", m_ds, -1);

    // R9 held word until ready returns
    req_word();
    starts = 0;
    for (int i = 0; i < 20; i++) begin tick(); starts += int'(!cs_n); end
    check("R9 word held", starts, 0);
    slave_en = 1'b1;
    k = 0;
    while (cs_n !== 1'b0 && k < 20) begin tick(); k++; end
    check("R9 release delay", k, 3);
    wait_start_or_to(n, kind);
    check("R9 then normal start", n, 4);
    finish_word(1'b0, m_cs, m_ds);

    // R5 unlimited pre-transfer wait, then R3 early end
    do_reset();
    set_cfg(2, 0, 1, 0, 1);
    slave_en = 1'b0; repeat (4) tick();
    req_word(); wait_cs(k);
    starts = 0;
    for (int i = 0; i < 40; i++) begin
      tick(); starts += int'(eng_start) + int'(timeout_evt) + int'(cs_n);
    end
    check("R5 waits without timeout", starts, 0);
    slave_en = 1'b1;
    wait_start_or_to(n, kind);
    check("R3 start after ready unlimited", n, 3);
    finish_word(1'b0, m_cs, m_ds);

    do_reset();
    set_cfg(2, 20, 1, 0, 1);
    slave_en = 1'b0; repeat (4) tick();
    req_word(); wait_cs(k);
    repeat (6) tick();
    slave_en = 1'b1;
    wait_start_or_to(n, kind);
    check("R3 window ends kind", kind, 1);
    check("R3 window ends delay", n, 3);
    check("R3 no timeout flag", int'(timeout_flag), 0);
    finish_word(1'b0, m_cs, m_ds);

    // R7 ready drops inside the post-transfer window
    do_reset();
    set_cfg(1, 0, 2, 10, 3);
    slave_en = 1'b1; repeat (4) tick();
    req_word(); wait_cs(k); wait_start_or_to(n, kind);
    repeat (3) tick();
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    m_cs = -1; m_ds = -1;
    for (int m = 1; m <= 40; m++) begin
      tick();
      if (m == 5) slave_en = 1'b0;
      if (m_cs < 0 && cs_n === 1'b1) m_cs = m;
      if (desync_evt === 1'b1) m_ds = m;
    end
    check("R12 release before window", m_cs, 2);
    check("R7 no desync", m_ds, -1);
    check("R7 desync flag", int'(desync_flag), 0);

    // R11 clear colliding with a new timeout
    do_reset();
    set_cfg(2, 4, 1, 0, 1);
    slave_en = 1'b0; repeat (4) tick();
    req_word(); wait_cs(k);
    repeat (5) tick();
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    check("R11 event in clear cycle", int'(timeout_evt), 1);
    check("R11 error wins over clear", int'(timeout_flag), 1);
    tick();
    check("R11 event one cycle", int'(timeout_evt), 0);
    check("R11 flag sticky", int'(timeout_flag), 1);
    err_clr = 1'b1; tick(); err_clr = 1'b0; tick();
    check("R11 flag cleared", int'(timeout_flag), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule